// File: doc/BRIEF.md
# Switchable Half-Band Decimation Chain

This block sits after the integrating-comb decimator in a receiver's resolution-bandwidth path. It lowers the sample rate further by a power of two. It is a chain of five identical stages. Each stage is a 19-tap half-band low-pass filter that keeps one output for every two input samples. A two-bit select sets how many of those stages the stream passes through: none, three or five. The overall rate reduction is therefore 1, 8 or 32.

All stages share one set of fixed coefficients. Every second tap of a half-band response is zero and the response is mirror-symmetric. So each stage first adds the two samples that share a coefficient, then multiplies only on the five distinct odd-offset values. The centre value is a power of two and is applied as a shift. Each stage rounds its result back to the input word width, so the word width stays the same along the chain. A change of the select clears every stage, so no output mixes samples from two settings.

Top module: `hb_cascade`

## Requirements
- R1: With select 0 the chain is bypassed. Every accepted input sample appears on the output, unchanged, one clock after it is accepted, with the output valid high in that cycle.
- R2: With select 1 the stream passes through three stages. Once the lines are full this gives one output for every 8 accepted inputs, and the total output count follows R6 applied three times.
- R3: With select 2 or select 3 the stream passes through five stages. This gives one output for every 32 accepted inputs, and the total output count follows R6 applied five times.
- R4: Each stage forms the sum over its 19 most recent samples of sample times coefficient, with the newest sample at position 0. The coefficient at the middle position 9 is 32768. At odd distances from the middle, on both sides, the values are 20400 at distance 1, -5200 at 3, 1700 at 5, -600 at 7 and 84 at 9. At even distances the value is 0. All values are scaled by 2^16.
- R5: Each stage rounds half upward by adding 2^15 and then shifting right arithmetically by 16. It saturates the result to the signed input width: 32767 and -32768 for a width of 16.
- R6: Counting from zero after a flush, a stage produces an output only when its input has an even index of 18 or more. A stage that has received n samples has therefore produced 0 outputs when n < 19, and (n-19)/2+1 outputs otherwise.
- R7: When the select differs from its value in the previous cycle, all stages are flushed. The input sample presented in that cycle is discarded, the output valid is low in the next cycle, and no output appears until the lines have refilled under R6.
- R8: While reset is high, the output valid is low and the output data is zero from the next clock onward.
- R9: A constant input passes with a gain of exactly one: once the lines are full, every output equals the input value.
- R10: Idle cycles between accepted samples, with input valid low, do not change any output value. Only accepted samples advance the filters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input sample valid |
| in_dat | input | DW | Signed input sample |
| stage_sel | input | 2 | Active stage count: 0 none, 1 three, 2 or 3 five |
| out_vld | output | 1 | Output sample valid |
| out_dat | output | DW | Signed output sample |

## Verification
Two functions can act in the same cycle: a change of the select and the acceptance of a sample. The bench provokes this by driving a new select together with a valid sample, after the chain has drained. It judges the result by checking three things: the output valid stays low in the next cycle, no expected value is left over, and the refill produces exactly the output count that R6 predicts for the samples after the change. A second collision, between an accepted sample and the stage's own output decision on that same sample, is judged through the every-clock comparison against the reference model. That comparison runs during a phase with irregular idle gaps.

// File: rtl/hb_pkg.sv
package hb_pkg;

    localparam int HB_TAPS        = 19;
    localparam int HB_MID         = (HB_TAPS - 1) / 2;
    localparam int HB_NMUL        = (HB_MID + 1) / 2;
    localparam int HB_CW          = 18;
    localparam int HB_CF          = 16;
    localparam int HB_MAX_STAGES  = 5;
    localparam int HB_CNTW        = $clog2(HB_TAPS);

    typedef enum logic [1:0] {
        SEL_BYPASS   = 2'd0,
        SEL_THREE    = 2'd1,
        SEL_FIVE     = 2'd2,
        SEL_FIVE_ALT = 2'd3
    } stage_sel_e;

    // distinct coefficient at odd distance 2*m+1 from the centre tap
    function automatic logic signed [HB_CW-1:0] hb_side_coef(input int m);
        case (m)
            0:       return 18'sd20400;
            1:       return -18'sd5200;
            2:       return 18'sd1700;
            3:       return -18'sd600;
            default: return 18'sd84;
        endcase
    endfunction

    function automatic logic [2:0] active_stages(input logic [1:0] sel);
        case (stage_sel_e'(sel))
            SEL_BYPASS: return 3'd0;
            SEL_THREE:  return 3'd3;
            default:    return 3'd5;
        endcase
    endfunction

endpackage

// File: rtl/hb_mac.sv
module hb_mac
    import hb_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic signed [DW-1:0] win [HB_TAPS],
    output logic signed [DW-1:0] y
);
    localparam int PW    = DW + 1 + HB_CW;
    localparam int ACC_W = DW + HB_CW + 4;

    localparam logic signed [ACC_W-1:0] RND  =
        {{(ACC_W-HB_CF){1'b0}}, 1'b1, {(HB_CF-1){1'b0}}};
    localparam logic signed [ACC_W-1:0] MAXV =
        {{(ACC_W-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] MINV =
        {{(ACC_W-DW+1){1'b1}}, {(DW-1){1'b0}}};

    logic signed [ACC_W-1:0] term [HB_NMUL];

    for (genvar m = 0; m < HB_NMUL; m++) begin : g_tap
        localparam logic signed [HB_CW-1:0] COEF = hb_side_coef(m);
        logic signed [DW:0]   pre;
        logic signed [PW-1:0] prod;
        // symmetric pre-addition: both mirror samples share one coefficient
        assign pre  = $signed({win[HB_MID-(2*m+1)][DW-1], win[HB_MID-(2*m+1)]})
                    + $signed({win[HB_MID+(2*m+1)][DW-1], win[HB_MID+(2*m+1)]});
        assign prod = PW'(pre) * PW'(COEF);
        assign term[m] = {{(ACC_W-PW){prod[PW-1]}}, prod};
    end

    logic signed [ACC_W-1:0] centre;
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] shifted;

    // centre coefficient is 2^(HB_CF-1): a shift instead of a multiplier
    assign centre = {{(ACC_W-DW-HB_CF+1){win[HB_MID][DW-1]}},
                     win[HB_MID], {(HB_CF-1){1'b0}}};

    always_comb begin
        acc = centre + RND;
        for (int m = 0; m < HB_NMUL; m++) begin
            acc = acc + term[m];
        end
        shifted = acc >>> HB_CF;
        if (shifted > MAXV) begin
            y = MAXV[DW-1:0];
        end else if (shifted < MINV) begin
            y = MINV[DW-1:0];
        end else begin
            y = shifted[DW-1:0];
        end
    end

endmodule

// File: rtl/hb_stage.sv
module hb_stage
    import hb_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  logic                 in_vld,
    input  logic signed [DW-1:0] in_dat,
    output logic                 out_vld,
    output logic signed [DW-1:0] out_dat
);
    localparam logic [HB_CNTW-1:0] FULL = HB_CNTW'(HB_TAPS - 1);

    logic signed [DW-1:0] win [HB_TAPS];
    logic [HB_CNTW-1:0]   seen;
    logic                 odd_ph;
    logic                 fire;
    logic signed [DW-1:0] mac_y;

    hb_mac #(.DW(DW)) u_mac (
        .win (win),
        .y   (mac_y)
    );

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int i = 0; i < HB_TAPS; i++) begin
                win[i] <= '0;
            end
            seen    <= '0;
            odd_ph  <= 1'b0;
            fire    <= 1'b0;
            out_vld <= 1'b0;
            out_dat <= '0;
        end else begin
            fire    <= in_vld && (seen == FULL) && !odd_ph;
            out_vld <= fire;
            if (fire) begin
                out_dat <= mac_y;
            end
            if (in_vld) begin
                win[0] <= in_dat;
                for (int i = 1; i < HB_TAPS; i++) begin
                    win[i] <= win[i-1];
                end
                odd_ph <= !odd_ph;
                if (seen != FULL) begin
                    seen <= seen + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/hb_route.sv
module hb_route
    import hb_pkg::*;
#(
    parameter int DW  = 16,
    parameter int NST = HB_MAX_STAGES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  logic [2:0]           n_act,
    input  logic                 tap_vld [NST+1],
    input  logic signed [DW-1:0] tap_dat [NST+1],
    output logic                 out_vld,
    output logic signed [DW-1:0] out_dat
);
    logic                 pick_vld;
    logic signed [DW-1:0] pick_dat;

    always_comb begin
        pick_vld = 1'b0;
        pick_dat = '0;
        for (int k = 0; k <= NST; k++) begin
            if (n_act == 3'(k)) begin
                pick_vld = tap_vld[k];
                pick_dat = tap_dat[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            out_dat <= '0;
        end else begin
            out_vld <= pick_vld && !flush;
            if (pick_vld && !flush) begin
                out_dat <= pick_dat;
            end
        end
    end

endmodule

// File: rtl/hb_cascade.sv
module hb_cascade
    import hb_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_vld,
    input  logic signed [DW-1:0] in_dat,
    input  logic [1:0]           stage_sel,
    output logic                 out_vld,
    output logic signed [DW-1:0] out_dat
);
    localparam int NST = HB_MAX_STAGES;

    logic [1:0] sel_q;
    logic       chg;
    logic [2:0] n_act;

    logic                 tap_vld [NST+1];
    logic signed [DW-1:0] tap_dat [NST+1];

    always_ff @(posedge clk) begin
        sel_q <= stage_sel;
    end

    assign chg   = (stage_sel != sel_q);
    assign n_act = active_stages(stage_sel);

    assign tap_vld[0] = in_vld;
    assign tap_dat[0] = in_dat;

    for (genvar k = 0; k < NST; k++) begin : g_stage
        logic gated_vld;
        // unused stages see no samples
        assign gated_vld = tap_vld[k] && (3'(k) < n_act);
        hb_stage #(.DW(DW)) u_stage (
            .clk     (clk),
            .rst     (rst),
            .flush   (chg),
            .in_vld  (gated_vld),
            .in_dat  (tap_dat[k]),
            .out_vld (tap_vld[k+1]),
            .out_dat (tap_dat[k+1])
        );
    end

    hb_route #(.DW(DW), .NST(NST)) u_route (
        .clk     (clk),
        .rst     (rst),
        .flush   (chg),
        .n_act   (n_act),
        .tap_vld (tap_vld),
        .tap_dat (tap_dat),
        .out_vld (out_vld),
        .out_dat (out_dat)
    );

endmodule

// File: rtl/hb_cascade_chk.sv
module hb_cascade_chk #(
    parameter int DW = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_vld,
    input logic signed [DW-1:0] in_dat,
    input logic [1:0]           stage_sel,
    input logic                 out_vld,
    input logic signed [DW-1:0] out_dat
);

    // R1
    bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (stage_sel == 2'd0 && $past(stage_sel) == 2'd0 && in_vld)
        |=> (out_vld && out_dat == $past(in_dat)));

    // R7
    sel_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (stage_sel != $past(stage_sel)) |=> !out_vld);

    // R8
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!out_vld && out_dat == '0));

    // R2 R3
    spaced_out_chk: assert property (@(posedge clk) disable iff (rst)
        (out_vld && stage_sel != 2'd0) |=> !out_vld);

endmodule

bind hb_cascade hb_cascade_chk #(.DW(DW)) u_hb_cascade_chk (
    .clk       (clk),
    .rst       (rst),
    .in_vld    (in_vld),
    .in_dat    (in_dat),
    .stage_sel (stage_sel),
    .out_vld   (out_vld),
    .out_dat   (out_dat)
);

// File: tb/test_hb_cascade.sv
`timescale 1ns/1ps
module test_hb_cascade;
    localparam int DW = 16;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_vld = 1'b0;
    logic signed [DW-1:0] in_dat = '0;
    logic [1:0]           stage_sel = 2'd0;
    logic                 out_vld;
    logic signed [DW-1:0] out_dat;

    hb_cascade #(.DW(DW)) i_hb_cascade (
        .clk       (clk),
        .rst       (rst),
        .in_vld    (in_vld),
        .in_dat    (in_dat),
        .stage_sel (stage_sel),
        .out_vld   (out_vld),
        .out_dat   (out_dat)
    );

    always #2.5 clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    bit done     = 0;

    // behavioural reference state
    int coef [19];
    int hist [5][19];
    int seen [5];
    int q [$];
    int cur_sel   = 0;
    bit byp_pend  = 0;
    int n_in      = 0;
    int n_out     = 0;
    int last_out  = 0;
    bit sat_seen  = 0;
    string data_req = "R4";
    int unsigned seed = 32'h1234_5678;

    task automatic report(input bit ok, input string req, input int got, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic int nstages(input int s);
        return (s == 0) ? 0 : (s == 1) ? 3 : 5;
    endfunction

    function automatic int outs_of(input int n);
        return (n < 19) ? 0 : (n - 19) / 2 + 1;
    endfunction

    function automatic int filt(input int k);
        longint acc = 0;
        longint r;
        for (int t = 0; t < 19; t++) acc += longint'(coef[t]) * hist[k][t];
        r = (acc + 32768) >>> 16;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    task automatic model_flush();
        for (int k = 0; k < 5; k++) begin
            seen[k] = 0;
            for (int t = 0; t < 19; t++) hist[k][t] = 0;
        end
        n_in = 0;
        n_out = 0;
    endtask

    task automatic model_feed(input int s);
        int v = s;
        bit go = 1;
        for (int k = 0; k < nstages(cur_sel) && go; k++) begin
            for (int t = 18; t > 0; t--) hist[k][t] = hist[k][t-1];
            hist[k][0] = v;
            if (seen[k] >= 18 && (seen[k] % 2 == 0)) v = filt(k);
            else go = 0;
            seen[k]++;
        end
        if (go) q.push_back(v);
    endtask

    task automatic tick(input bit v, input int d, input int s);
        int e;
        @(negedge clk);
        if (out_vld) begin
            n_out++;
            last_out = int'(out_dat);
            if (out_dat == 16'sh7fff || out_dat == -16'sh8000) sat_seen = 1;
            if (q.size() == 0) begin
                report(0, data_req, int'(out_dat), 0);
            end else begin
                e = q.pop_front();
                report(int'(out_dat) == e, data_req, int'(out_dat), e);
            end
        end
        if (byp_pend) report(out_vld, "R1", int'(out_vld), 1);
        byp_pend = 0;
        in_vld = v;
        in_dat = DW'(d);
        stage_sel = 2'(s);
        if (s != cur_sel) begin
            cur_sel = s;
            model_flush();
        end else if (v) begin
            model_feed(int'($signed(in_dat)));
            n_in++;
            if (cur_sel == 0) byp_pend = 1;
        end
    endtask

    function automatic int lcg_sample();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed[23:8]) - 32768;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_fails++;
            $display("FAIL watchdog: got %0d expected %0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        coef = '{default: 0};
        coef[9] = 32768;
        coef[8] = 20400; coef[10] = 20400;
        coef[6] = -5200; coef[12] = -5200;
        coef[4] = 1700;  coef[14] = 1700;
        coef[2] = -600;  coef[16] = -600;
        coef[0] = 84;    coef[18] = 84;
        model_flush();

        // R8: reset state
        repeat (4) @(negedge clk);
        report(!out_vld, "R8", int'(out_vld), 0);
        report(out_dat == 0, "R8", int'(out_dat), 0);
        rst = 1'b0;

        // R1: bypass with irregular valid
        data_req = "R1";
        for (int i = 0; i < 60; i++) tick((i % 5) != 3, lcg_sample(), 0);
        for (int i = 0; i < 4; i++) tick(0, 0, 0);
        report(q.size() == 0, "R1", q.size(), 0);

        // R7: change select together with a valid sample
        data_req = "R7";
        tick(1, 777, 1);
        tick(0, 0, 1);
        report(!out_vld, "R7", int'(out_vld), 0);

        // R4 R2 R6: three stages, random full-scale data every cycle
        data_req = "R4";
        for (int i = 0; i < 700; i++) tick(1, lcg_sample(), 1);
        for (int i = 0; i < 40; i++) tick(0, 0, 1);
        report(q.size() == 0, "R4", q.size(), 0);
        report(n_out == outs_of(outs_of(outs_of(n_in))), "R2 R6", n_out,
               outs_of(outs_of(outs_of(n_in))));

        // R5: full-scale square wave overshoots and saturates
        data_req = "R5";
        for (int i = 0; i < 800; i++) tick(1, ((i / 40) % 2) ? 32767 : -32768, 1);
        for (int i = 0; i < 40; i++) tick(0, 0, 1);
        report(sat_seen, "R5", int'(sat_seen), 1);
        report(q.size() == 0, "R5", q.size(), 0);

        // R10 R3: five stages, gaps in valid
        data_req = "R10";
        tick(0, 0, 2);
        for (int i = 0; i < 3000; i++) tick((i % 7) < 5, lcg_sample(), 2);
        for (int i = 0; i < 120; i++) tick(0, 0, 2);
        report(q.size() == 0, "R10", q.size(), 0);
        report(n_out == outs_of(outs_of(outs_of(outs_of(outs_of(n_in))))), "R3", n_out,
               outs_of(outs_of(outs_of(outs_of(outs_of(n_in))))));

        // R9: DC through five stages via the alternate code
        data_req = "R9";
        tick(0, 0, 3);
        for (int i = 0; i < 1600; i++) tick(1, 1234, 3);
        for (int i = 0; i < 120; i++) tick(0, 0, 3);
        report(last_out == 1234, "R9", last_out, 1234);
        report(n_out == outs_of(outs_of(outs_of(outs_of(outs_of(n_in))))), "R3", n_out,
               outs_of(outs_of(outs_of(outs_of(outs_of(n_in))))));

        // R7 R1: back to bypass, sample in the change cycle is dropped
        data_req = "R7";
        tick(1, 4321, 0);
        tick(1, 100, 0);
        report(!out_vld, "R7", int'(out_vld), 0);
        data_req = "R1";
        for (int i = 0; i < 20; i++) tick(1, lcg_sample(), 0);
        for (int i = 0; i < 4; i++) tick(0, 0, 0);
        report(q.size() == 0, "R1", q.size(), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule